// File: doc/BRIEF.md
# Speculative Load Tracking Table

This block keeps a small associative record of loads that a compiler has moved above earlier stores whose addresses were unknown at schedule time. When such a hoisted load executes, the pipeline writes its destination register, start address and access size into the table. Each later store presents its own address and size. Any recorded load whose byte range touches the store's byte range is dropped from the table.

When the consumer of the hoisted value is reached, the pipeline asks the table by destination register whether the entry survived. A hit means no aliasing store intervened and the speculative value may be used. A miss means the entry was never written, was overwritten, was evicted, or was killed by a store, and the load has to be executed again. The check can optionally consume the entry on a hit. A single-cycle flush empties the whole table, for example on a context switch.

The tag is 8 bits: bit 7 selects the register class (0 integer, 1 floating point) and bits 6:0 give the register number. Access sizes are encoded as a power of two, with length = 1 << code.

Top module: `spec_load_table`

## Requirements
- R1: After reset, and before any load is recorded, every check reports a miss (`chk_hit` = 0).
- R2: A recorded load makes a later check with the same 8-bit tag hit. A tag that differs in any bit, including the class bit 7, misses.
- R3: The table holds at most one valid entry per tag. A new load with a tag already present overwrites that entry in place, and only the new address and size are compared against later stores.
- R4: A load with a new tag goes into the lowest-numbered free slot. When all 32 slots are valid, it replaces the slot named by a round-robin pointer. The pointer starts at slot 0 after reset or flush and moves up by one (wrapping) only on such an eviction.
- R5: A store kills every valid entry whose byte range [addr, addr + (1 << size_code)) intersects the store's range [st_addr, st_addr + (1 << st_size)). Size codes 0 to 4 mean 1, 2, 4, 8 and 16 bytes, and ranges do not wrap past the top of the address space.
- R6: A store whose byte range does not intersect an entry, including a range that only abuts it, leaves that entry valid.
- R7: When a load is recorded and a store is presented in the same cycle, the store is compared against the newly written entry. If they overlap, the new entry is not left valid.
- R8: A plain check (`chk_clear` = 0) leaves the entry in place. A check with `chk_clear` = 1 that hits removes the entry, so the next check of that tag misses.
- R9: `flush_all` empties every entry in one cycle and resets the round-robin pointer. It takes precedence over a load, store or check-and-clear in the same cycle.
- R10: `chk_hit` is combinational and reflects the table as it stood before the current cycle's load, store, clear or flush take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_all | input | 1 | Empty the whole table at this edge |
| ld_valid | input | 1 | Record a hoisted load this cycle |
| ld_tag | input | 8 | Load destination: bit 7 class, bits 6:0 register |
| ld_addr | input | 32 | Load start byte address |
| ld_size | input | 3 | Load size code, length = 1 << code |
| st_valid | input | 1 | Store snoop this cycle |
| st_addr | input | 32 | Store start byte address |
| st_size | input | 3 | Store size code, length = 1 << code |
| chk_valid | input | 1 | Check request this cycle |
| chk_tag | input | 8 | Tag being checked |
| chk_clear | input | 1 | Remove the entry if the check hits |
| chk_hit | output | 1 | Entry for `chk_tag` is present and valid |

## Verification
The overlap rule is swept with the entry fixed at one address. Every pairing of the five entry sizes with the five store sizes is tried, with store start offsets from 20 bytes below to 20 bytes above the entry. This separates true intersection from ranges that abut on either side or lie just one byte apart. Separate sequences fill the table with distinct tags to tell lowest-free placement apart from round-robin eviction, and re-record an existing tag to show the old range no longer matters. Further sequences put a load, store, check or flush in the same cycle as another operation, which exposes same-cycle ordering and precedence.

// File: rtl/spec_load_table.sv
`timescale 1ns/1ps
module spec_load_table #(
  parameter int ENTRIES = 32,
  parameter int TAG_W   = 8,
  parameter int ADDR_W  = 32,
  parameter int SIZE_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_all,
  input  logic              ld_valid,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [SIZE_W-1:0] ld_size,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [SIZE_W-1:0] st_size,
  input  logic              chk_valid,
  input  logic [TAG_W-1:0]  chk_tag,
  input  logic              chk_clear,
  output logic              chk_hit
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int EXT_W = ADDR_W + 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  function automatic logic ranges_meet(input logic [ADDR_W-1:0] a, input logic [SIZE_W-1:0] sa,
                                       input logic [ADDR_W-1:0] b, input logic [SIZE_W-1:0] sb);
    logic [EXT_W-1:0] a_lo, a_end, b_lo, b_end;
    a_lo  = {1'b0, a};
    b_lo  = {1'b0, b};
    a_end = a_lo + (EXT_W'(1) << sa);
    b_end = b_lo + (EXT_W'(1) << sb);
    return (a_lo < b_end) && (b_lo < a_end);
  endfunction

  logic              valid_q [ENTRIES];
  logic [TAG_W-1:0]  tag_q   [ENTRIES];
  logic [ADDR_W-1:0] addr_q  [ENTRIES];
  logic [SIZE_W-1:0] size_q  [ENTRIES];
  logic [ENTRIES-1:0] valid_vec, ld_match, chk_match, st_hit;
  logic [IDX_W-1:0]  rr_q, alloc_idx;
  logic              alloc_victim;
  logic              ld_st_meet;

  assign ld_st_meet = st_valid && ranges_meet(ld_addr, ld_size, st_addr, st_size);
  assign chk_hit    = chk_valid && (|chk_match);

  always_comb begin
    alloc_idx    = rr_q;
    alloc_victim = 1'b1;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        alloc_idx    = IDX_W'(i);
        alloc_victim = 1'b0;
      end
    end
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (ld_match[i]) begin
        alloc_idx    = IDX_W'(i);
        alloc_victim = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       rr_q <= '0;
    else if (flush_all)               rr_q <= '0;
    else if (ld_valid && alloc_victim) rr_q <= (rr_q == LAST_IDX) ? '0 : rr_q + 1'b1;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic take;
    assign take         = ld_valid && (alloc_idx == IDX_W'(g));
    assign valid_vec[g] = valid_q[g];
    assign ld_match[g]  = valid_q[g] && (tag_q[g] == ld_tag);
    assign chk_match[g] = valid_q[g] && (tag_q[g] == chk_tag);
    assign st_hit[g]    = st_valid && valid_q[g] &&
                          ranges_meet(addr_q[g], size_q[g], st_addr, st_size);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         valid_q[g] <= 1'b0;
      else if (flush_all) valid_q[g] <= 1'b0;
      else if (take)      valid_q[g] <= !ld_st_meet;
      else if (st_hit[g] || (chk_valid && chk_clear && chk_match[g]))
                          valid_q[g] <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (take && !flush_all) begin
        tag_q[g]  <= ld_tag;
        addr_q[g] <= ld_addr;
        size_q[g] <= ld_size;
      end
    end
  end

  assert_one_entry_per_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ld_match));

  assert_victim_only_when_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && alloc_victim) |-> (&valid_vec));

  assert_load_recorded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !flush_all && !ld_st_meet) |=>
      (valid_q[$past(alloc_idx)] && (tag_q[$past(alloc_idx)] == $past(ld_tag))));

  assert_store_kills_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !ld_valid && !flush_all) |=> ((valid_vec & $past(st_hit)) == '0));

  assert_check_clear_removes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_hit && chk_clear && !ld_valid && !flush_all) |=> ((valid_vec & $past(chk_match)) == '0));

  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (valid_vec == '0));
endmodule

// File: tb/spec_load_table_tb.sv
`timescale 1ns/1ps
module spec_load_table_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, flush_all, ld_valid, st_valid, chk_valid, chk_clear, chk_hit;
  logic [7:0]  ld_tag, chk_tag;
  logic [31:0] ld_addr, st_addr;
  logic [2:0]  ld_size, st_size;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  spec_load_table dut_i (
    .clk(clk), .rst_n(rst_n), .flush_all(flush_all),
    .ld_valid(ld_valid), .ld_tag(ld_tag), .ld_addr(ld_addr), .ld_size(ld_size),
    .st_valid(st_valid), .st_addr(st_addr), .st_size(st_size),
    .chk_valid(chk_valid), .chk_tag(chk_tag), .chk_clear(chk_clear),
    .chk_hit(chk_hit));

  task automatic idle();
    flush_all = 0; ld_valid = 0; st_valid = 0; chk_valid = 0; chk_clear = 0;
    ld_tag = 0; chk_tag = 0; ld_addr = 0; st_addr = 0; ld_size = 0; st_size = 0;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk); idle();
  endtask

  task automatic expect_bit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic set_load(logic [7:0] t, logic [31:0] a, logic [2:0] s);
    ld_valid = 1; ld_tag = t; ld_addr = a; ld_size = s;
  endtask

  task automatic set_store(logic [31:0] a, logic [2:0] s);
    st_valid = 1; st_addr = a; st_size = s;
  endtask

  task automatic probe(string req, logic [7:0] t, logic clr, logic exp);
    chk_valid = 1; chk_tag = t; chk_clear = clr;
    #2 expect_bit(req, chk_hit, exp);
    tick();
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: empty after reset
    probe("R1 empty tag0", 8'h00, 0, 0);
    probe("R1 empty tag85", 8'h85, 0, 0);

    // R2: record and look up, class bit distinguishes
    set_load(8'h05, 32'h200, 3'd2); tick();
    probe("R2 same tag hits", 8'h05, 0, 1);
    probe("R2 class bit differs", 8'h85, 0, 0);
    probe("R2 register differs", 8'h04, 0, 0);

    // R8: plain check keeps, check-and-clear removes
    probe("R8 plain check keeps", 8'h05, 0, 1);
    probe("R8 clear check hits", 8'h05, 1, 1);
    probe("R8 entry gone after clear", 8'h05, 0, 0);

    // R3: re-record replaces old range
    set_load(8'h07, 32'h300, 3'd0); tick();
    set_load(8'h07, 32'h400, 3'd0); tick();
    set_store(32'h300, 3'd0); tick();
    probe("R3 old range ignored", 8'h07, 0, 1);
    set_store(32'h400, 3'd0); tick();
    probe("R3 new range compared", 8'h07, 0, 0);

    // R5/R6: overlap sweep over size pairs and offsets
    for (int se = 0; se < 5; se++)
      for (int ss = 0; ss < 5; ss++)
        for (int d = -20; d <= 20; d++) begin
          int e_lo, e_hi, s_lo, s_hi;
          bit ov;
          e_lo = 256; e_hi = 256 + (1 << se);
          s_lo = 256 + d; s_hi = s_lo + (1 << ss);
          ov = (s_lo < e_hi) && (e_lo < s_hi);
          set_load(8'h03, 32'h100, 3'(se)); tick();
          set_store(32'(s_lo), 3'(ss)); tick();
          if (ov) probe("R5 overlapping store kills", 8'h03, 0, 0);
          else    probe("R6 disjoint store keeps", 8'h03, 0, 1);
        end

    // R7: same-cycle load and store
    set_load(8'h10, 32'h500, 3'd3); set_store(32'h507, 3'd0); tick();
    probe("R7 same-cycle overlap kills", 8'h10, 0, 0);
    set_load(8'h11, 32'h600, 3'd3); set_store(32'h608, 3'd0); tick();
    probe("R7 same-cycle disjoint keeps", 8'h11, 0, 1);

    // R9: flush clears all and beats a same-cycle load
    flush_all = 1; set_load(8'h12, 32'h700, 3'd0); tick();
    probe("R9 flushed entry", 8'h11, 0, 0);
    probe("R9 flush beats load", 8'h12, 0, 0);

    // R4: fill, then lowest-free and round-robin eviction
    for (int t = 0; t < 32; t++) begin
      set_load(8'(t), 32'h1000 + 32'(16 * t), 3'd0); tick();
    end
    for (int t = 0; t < 32; t++) probe("R4 filled table hit", 8'(t), 0, 1);
    set_load(8'd40, 32'h3000, 3'd0); tick();
    probe("R4 first victim slot0", 8'd0, 0, 0);
    probe("R4 new tag present", 8'd40, 0, 1);
    probe("R4 slot1 kept", 8'd1, 0, 1);
    set_load(8'd41, 32'h3010, 3'd0); tick();
    probe("R4 second victim slot1", 8'd1, 0, 0);
    set_store(32'h1050, 3'd0); tick();
    probe("R4 tag5 killed", 8'd5, 0, 0);
    set_load(8'd42, 32'h3020, 3'd0); tick();
    probe("R4 free slot used not victim", 8'd2, 0, 1);
    probe("R4 tag42 placed", 8'd42, 0, 1);
    set_load(8'd43, 32'h3030, 3'd0); tick();
    probe("R4 pointer moved to slot2", 8'd2, 0, 0);
    probe("R4 slot3 kept", 8'd3, 0, 1);

    // R10: check sees state before same-cycle updates
    flush_all = 1; tick();
    set_load(8'h09, 32'h800, 3'd0); chk_valid = 1; chk_tag = 8'h09;
    #2 expect_bit("R10 check before load lands", chk_hit, 0);
    tick();
    probe("R10 load visible next cycle", 8'h09, 0, 1);
    set_store(32'h800, 3'd0); chk_valid = 1; chk_tag = 8'h09;
    #2 expect_bit("R10 check before store lands", chk_hit, 1);
    tick();
    probe("R10 store visible next cycle", 8'h09, 0, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule